// File: doc/BRIEF.md
# Keyboard and Beeper Port Decoder

This block is the single input/output port of a small home computer, seen from the processor's I/O bus. Every I/O cycle whose address has a zero in bit 0 belongs to it. A write to the port stores a three-bit border colour, a tape-output enable and a speaker enable. A read from the port scans an eight-by-five key matrix. The upper byte of the address chooses which half-rows are scanned. The read also returns the tape comparator level and two bits that are always one.

Key states and the tape comparator level arrive from outside and are captured in registers once per clock. The read data is then formed combinationally from those registers and the current address. Several half-rows may be addressed at once, and their active-low key bits are combined with AND. The speaker and the tape-input sense share one physical pin, so the tape bit that is read back is pulled low by the block's own speaker setting. A parameter selects between two rules for this pull-down.

Top module: `kbp_port_unit`

## Requirements
- R1: An access is for this port only when address bit 0 is 0. A write to an odd address leaves every output unchanged. A read from an odd address returns 8'hFF.
- R2: A port write stores data[2:0] as `border_col`, drives `spk_on` equal to data[4], and drives `mic_on` equal to the inverse of data[3]. Data bits 7..5 have no effect.
- R3: After reset, `border_col` is 0, `spk_on` is 0 and `mic_on` is 1. The stored copies of data bits 3 and 4 are both 0.
- R4: On a port read, address bit 8+r equal to 0 selects half-row r (r = 0..7). Read bit c (c = 0..4) is 0 when key index r*5+c of `key_down` is pressed (1). Keys in half-rows that are not selected have no effect.
- R5: When several half-rows are selected, read bits 4..0 are the bitwise AND of the active-low values of those rows.
- R6: When address bits 15..8 are all 1, read bits 4..0 are 5'b11111 whatever keys are pressed.
- R7: Read bits 7 and 5 of a port read are always 1.
- R8: When the stored speaker bit is 1, read bit 6 equals the registered `tape_in` level.
- R9: In the default mode (TAPE_FORCE_BOTH=0), read bit 6 is 0 whenever the stored speaker bit is 0. In the alternate mode (TAPE_FORCE_BOTH=1), read bit 6 is forced to 0 only when the stored speaker bit and the stored data bit 3 are both 0.
- R10: `key_down` and `tape_in` are captured on the rising clock edge. A change becomes visible in `rd_data` after the next edge and not before it. A port write becomes visible on the outputs after the edge on which `io_wr` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | I/O address from the processor |
| cpu_wdata | input | 8 | Write data |
| io_wr | input | 1 | I/O write strobe, sampled on the clock edge |
| io_rd | input | 1 | I/O read strobe |
| key_down | input | 40 | Key pressed vector, index row*5+column, 1 = pressed |
| tape_in | input | 1 | Tape comparator level |
| border_col | output | 3 | Latched border colour |
| mic_on | output | 1 | Tape-output line enable |
| spk_on | output | 1 | Speaker enable |
| rd_data | output | 8 | Read data bus |

## Verification
A wrong stored speaker or tape-output bit does not stay hidden inside the block. It shows in `spk_on` and `mic_on`, and in bit 6 of the very next port read. A wrong border field shows in `border_col` one edge after the write. A fault in the row decode or in the AND combine shows only when the right half-row pattern is addressed. For that reason the bench walks every row and also addresses rows together, with keys placed in rows that are not selected. A fault in the input registers shows as a read that changes one cycle too early or one cycle too late around a key change.

// File: rtl/kbp_pkg.sv
package kbp_pkg;
   localparam int KBP_ROWS     = 8;
   localparam int KBP_COLS     = 5;
   localparam int KBP_ADDR_W   = 16;
   localparam int KBP_DATA_W   = 8;
   localparam int KBP_BORDER_W = 3;

   // Positions of the write fields inside the data byte
   localparam int WR_MIC_BIT = 3;
   localparam int WR_SPK_BIT = 4;

   // Positions of the read fields inside the data byte
   localparam int RD_FIX_LO  = 5;
   localparam int RD_TAPE    = 6;
   localparam int RD_FIX_HI  = 7;

   typedef struct packed {
      logic       spk_raw;
      logic       mic_raw;
      logic [KBP_BORDER_W-1:0] border;
   } kbp_out_t;
endpackage

// File: rtl/kbp_in_stage.sv
module kbp_in_stage #(
   parameter int KEYS = 40
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [KEYS-1:0] key_down,
   input  logic            tape_in,
   output logic [KEYS-1:0] keys_q,
   output logic            tape_q
);
   initial begin
      if (KEYS < 1) $error("kbp_in_stage: KEYS must be positive");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         keys_q <= '0;
         tape_q <= 1'b0;
      end else begin
         keys_q <= key_down;
         tape_q <= tape_in;
      end
   end

   p_capture_r10: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (keys_q == $past(key_down)) && (tape_q == $past(tape_in)));
endmodule

// File: rtl/kbp_out_latch.sv
module kbp_out_latch
   import kbp_pkg::*;
#(
   parameter int DATA_W   = KBP_DATA_W,
   parameter int BORDER_W = KBP_BORDER_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_hit,
   input  logic              wr_odd,
   input  logic [DATA_W-1:0] wdata,
   output kbp_out_t          out_q
);
   initial begin
      if (BORDER_W != KBP_BORDER_W) $error("kbp_out_latch: border width mismatch");
      if (DATA_W <= WR_SPK_BIT) $error("kbp_out_latch: data too narrow");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_q <= '0;
      end else if (wr_hit) begin
         out_q.border  <= wdata[BORDER_W-1:0];
         out_q.mic_raw <= wdata[WR_MIC_BIT];
         out_q.spk_raw <= wdata[WR_SPK_BIT];
      end
   end

   logic unused_hi;
   assign unused_hi = ^wdata[DATA_W-1:WR_SPK_BIT+1];

   p_wr_fields_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit |=> (out_q.border == $past(wdata[BORDER_W-1:0]))
              && (out_q.spk_raw == $past(wdata[WR_SPK_BIT]))
              && (out_q.mic_raw == $past(wdata[WR_MIC_BIT])));

   p_odd_wr_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_odd && !wr_hit) |=> $stable(out_q));
endmodule

// File: rtl/kbp_matrix_scan.sv
module kbp_matrix_scan #(
   parameter int ROWS = 8,
   parameter int COLS = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ROWS*COLS-1:0] keys_q,
   input  logic [ROWS-1:0]      row_sel_n,
   output logic [COLS-1:0]      cols_n
);
   initial begin
      if (ROWS < 1 || COLS < 1) $error("kbp_matrix_scan: empty matrix");
   end

   logic [COLS-1:0] row_term [ROWS];

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      assign row_term[r] = row_sel_n[r] ? {COLS{1'b1}} : ~keys_q[r*COLS +: COLS];
   end

   always_comb begin
      cols_n = {COLS{1'b1}};
      for (int r = 0; r < ROWS; r++) cols_n = cols_n & row_term[r];
   end

   p_idle_rows_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (&row_sel_n) |-> (&cols_n));

   p_row0_press_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!row_sel_n[0] && keys_q[0]) |-> !cols_n[0]);
endmodule

// File: rtl/kbp_tape_sense.sv
module kbp_tape_sense #(
   parameter bit TAPE_FORCE_BOTH = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tape_q,
   input  logic spk_raw,
   input  logic mic_raw,
   output logic tape_bit
);
   logic pull_low;

   if (TAPE_FORCE_BOTH) begin : g_both
      assign pull_low = !spk_raw && !mic_raw;
      p_force_both_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (!spk_raw && mic_raw) |-> (tape_bit == tape_q));
   end else begin : g_spk
      assign pull_low = !spk_raw;
      logic unused_mic;
      assign unused_mic = mic_raw;
      p_force_spk_r9: assert property (@(posedge clk) disable iff (!rst_n)
         !spk_raw |-> !tape_bit);
   end

   assign tape_bit = tape_q && !pull_low;

   p_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
      spk_raw |-> (tape_bit == tape_q));
endmodule

// File: rtl/kbp_port_unit.sv
module kbp_port_unit
   import kbp_pkg::*;
#(
   parameter int ADDR_W          = KBP_ADDR_W,
   parameter int DATA_W          = KBP_DATA_W,
   parameter int ROWS            = KBP_ROWS,
   parameter int COLS            = KBP_COLS,
   parameter bit TAPE_FORCE_BOTH = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    cpu_addr,
   input  logic [DATA_W-1:0]    cpu_wdata,
   input  logic                 io_wr,
   input  logic                 io_rd,
   input  logic [ROWS*COLS-1:0] key_down,
   input  logic                 tape_in,
   output logic [2:0]           border_col,
   output logic                 mic_on,
   output logic                 spk_on,
   output logic [DATA_W-1:0]    rd_data
);
   localparam int KEYS     = ROWS * COLS;
   localparam int ROW_BASE = ADDR_W - ROWS;

   initial begin
      if (DATA_W != 8) $error("kbp_port_unit: data bus must be 8 bits");
      if (COLS != RD_FIX_LO) $error("kbp_port_unit: columns must fill bits below the fixed bit");
      if (ROW_BASE < 1) $error("kbp_port_unit: address too narrow for row select");
   end

   logic            port_hit, wr_hit, wr_odd, rd_hit;
   logic [KEYS-1:0] keys_q;
   logic            tape_q, tape_bit;
   logic [COLS-1:0] cols_n;
   kbp_out_t        out_q;

   assign port_hit = !cpu_addr[0];
   assign wr_hit   = io_wr && port_hit;
   assign wr_odd   = io_wr && !port_hit;
   assign rd_hit   = io_rd && port_hit;

   logic unused_addr;
   assign unused_addr = ^cpu_addr[ROW_BASE-1:1];

   kbp_in_stage #(.KEYS(KEYS)) in_i (
      .clk(clk), .rst_n(rst_n), .key_down(key_down), .tape_in(tape_in),
      .keys_q(keys_q), .tape_q(tape_q));

   kbp_out_latch #(.DATA_W(DATA_W), .BORDER_W(KBP_BORDER_W)) out_i (
      .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .wr_odd(wr_odd),
      .wdata(cpu_wdata), .out_q(out_q));

   kbp_matrix_scan #(.ROWS(ROWS), .COLS(COLS)) scan_i (
      .clk(clk), .rst_n(rst_n), .keys_q(keys_q),
      .row_sel_n(cpu_addr[ADDR_W-1:ROW_BASE]), .cols_n(cols_n));

   kbp_tape_sense #(.TAPE_FORCE_BOTH(TAPE_FORCE_BOTH)) tape_i (
      .clk(clk), .rst_n(rst_n), .tape_q(tape_q), .spk_raw(out_q.spk_raw),
      .mic_raw(out_q.mic_raw), .tape_bit(tape_bit));

   assign border_col = out_q.border;
   assign mic_on     = !out_q.mic_raw;
   assign spk_on     = out_q.spk_raw;

   always_comb begin
      rd_data = '1;
      if (rd_hit) begin
         rd_data[COLS-1:0] = cols_n;
         rd_data[RD_TAPE]  = tape_bit;
      end
   end

   p_fixed_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_hit |-> (rd_data[RD_FIX_HI] && rd_data[RD_FIX_LO]));

   p_odd_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && cpu_addr[0]) |-> (rd_data == 8'hFF));

   p_reset_state_r3: assert property (@(posedge clk)
      $past(!rst_n) |-> (border_col == 3'd0 && mic_on && !spk_on));
endmodule

// File: tb/kbp_port_unit_tb_top.sv
module kbp_port_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = 16'hFFFF;
   logic [7:0]  cpu_wdata = 8'h00;
   logic        io_wr = 1'b0, io_rd = 1'b0;
   logic [39:0] key_down = '0;
   logic        tape_in = 1'b0;
   logic [2:0]  border_col, border_alt;
   logic        mic_on, spk_on, mic_alt, spk_alt;
   logic [7:0]  rd_data, rd_alt;

   int checks = 0;
   int errors = 0;

   // model state kept by the bench
   logic        m_spk = 1'b0, m_mic = 1'b0;
   logic [39:0] m_keys = '0;
   logic        m_tape = 1'b0;

   always #2.5 clk = ~clk;

   kbp_port_unit dut_i (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .io_wr(io_wr), .io_rd(io_rd), .key_down(key_down), .tape_in(tape_in),
      .border_col(border_col), .mic_on(mic_on), .spk_on(spk_on), .rd_data(rd_data));

   kbp_port_unit #(.TAPE_FORCE_BOTH(1'b1)) dut_alt_i (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .io_wr(io_wr), .io_rd(io_rd), .key_down(key_down), .tape_in(tape_in),
      .border_col(border_alt), .mic_on(mic_alt), .spk_on(spk_alt), .rd_data(rd_alt));

   function automatic logic [7:0] exp_rd(input logic [15:0] a, input logic [39:0] k,
                                         input logic t, input logic s, input logic m,
                                         input logic both);
      logic [4:0] c;
      logic       tb6;
      if (a[0]) return 8'hFF;
      c = 5'h1F;
      for (int r = 0; r < 8; r++)
         if (!a[8+r])
            for (int j = 0; j < 5; j++)
               if (k[r*5+j]) c[j] = 1'b0;
      tb6 = both ? (t && (s || m)) : (t && s);
      return {1'b1, tb6, 1'b1, c};
   endfunction

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_write(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      cpu_addr = a; cpu_wdata = d; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0;
      if (!a[0]) begin m_spk = d[4]; m_mic = d[3]; end
   endtask

   task automatic set_inputs(input logic [39:0] k, input logic t);
      @(negedge clk);
      key_down = k; tape_in = t;
      @(negedge clk);
      m_keys = k; m_tape = t;
   endtask

   task automatic read_chk(input string req, input logic [15:0] a);
      @(negedge clk);
      cpu_addr = a; io_rd = 1'b1;
      #1;
      check(req, rd_data, exp_rd(a, m_keys, m_tape, m_spk, m_mic, 1'b0));
      check(req, rd_alt,  exp_rd(a, m_keys, m_tape, m_spk, m_mic, 1'b1));
      io_rd = 1'b0;
   endtask

   task automatic t_reset;
      @(negedge clk);
      check("R3 border", {5'd0, border_col}, 8'd0);
      check("R3 mic/spk", {6'd0, mic_on, spk_on}, 8'b10);
      read_chk("R3 R7 reset read", 16'hFEFE);
   endtask

   task automatic t_write;
      do_write(16'h00FE, 8'hF5);
      check("R2 border", {5'd0, border_col}, 8'd5);
      check("R2 mic/spk", {6'd0, mic_on, spk_on}, 8'b11);
      do_write(16'h1234, 8'h0A);
      check("R2 border2", {5'd0, border_col}, 8'd2);
      check("R2 mic/spk2", {6'd0, mic_on, spk_on}, 8'b00);
      do_write(16'h00FF, 8'h17);
      check("R1 odd write border", {5'd0, border_col}, 8'd2);
      check("R1 odd write mic/spk", {6'd0, mic_on, spk_on}, 8'b00);
   endtask

   task automatic t_rows;
      do_write(16'h00FE, 8'h10);
      for (int r = 0; r < 8; r++) begin
         logic [39:0] k;
         k = '0;
         k[r*5 + (r % 5)] = 1'b1;
         k[((r+1)%8)*5 + ((r+2) % 5)] = 1'b1;
         set_inputs(k, 1'b1);
         read_chk("R4 single row", {~(8'h01 << r), 8'hFE});
      end
      read_chk("R1 odd read", 16'h00FF);
   endtask

   task automatic t_multi;
      logic [39:0] k;
      k = '0;
      k[1*5+2] = 1'b1;
      k[6*5+4] = 1'b1;
      k[3*5+0] = 1'b1;
      set_inputs(k, 1'b1);
      read_chk("R5 two rows", 16'hBDFE);
      read_chk("R5 all rows", 16'h00FE);
      read_chk("R6 no row", 16'hFFFE);
   endtask

   task automatic t_tape;
      set_inputs('0, 1'b1);
      do_write(16'h00FE, 8'h10);
      read_chk("R8 tape high", 16'hFFFE);
      set_inputs('0, 1'b0);
      read_chk("R8 tape low", 16'hFFFE);
      set_inputs('0, 1'b1);
      do_write(16'h00FE, 8'h08);
      read_chk("R9 spk0 mic bit1", 16'hFFFE);
      do_write(16'h00FE, 8'h00);
      read_chk("R9 spk0 mic bit0", 16'hFFFE);
   endtask

   task automatic t_latency;
      logic [39:0] k;
      do_write(16'h00FE, 8'h10);
      set_inputs('0, 1'b1);
      k = '0;
      k[0] = 1'b1;
      @(negedge clk);
      key_down = k; cpu_addr = 16'hFEFE; io_rd = 1'b1;
      #1;
      check("R10 before edge", rd_data, exp_rd(16'hFEFE, '0, 1'b1, 1'b1, 1'b0, 1'b0));
      @(negedge clk);
      #1;
      check("R10 after edge", rd_data, exp_rd(16'hFEFE, k, 1'b1, 1'b1, 1'b0, 1'b0));
      io_rd = 1'b0;
      m_keys = k;
   endtask

   initial begin
      #1000000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_write();
      t_rows();
      t_multi();
      t_tape();
      t_latency();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule